// File: doc/BRIEF.md
# Memory Request Coalescing Unit

This unit sits between the lanes of a thread group and the memory controller. A group arrives as one word: one byte address per lane and a mask of the lanes that are active. The unit turns that group into the smallest set of memory transactions. Each transaction covers one aligned segment whose size is the bus width. Lanes whose addresses fall in the same segment share a single transaction. A group in which consecutive lanes touch consecutive bytes of one segment therefore costs one transaction. A single lane that strays outside that segment adds a second one.

The unit issues transactions one per cycle over a valid/ready handshake. Each transaction carries the segment base address and a mask of the lanes it serves. The lowest-numbered lane that has not yet been served chooses the segment for the next transaction. Every other pending lane that lands in that segment is served along with it. When the last active lane has been served, the unit pulses a done signal and reports how many transactions the group took. It accepts the next group only after that pulse. The lane count, address width and segment size are parameters.

Top module: `mem_coalescer`

## Requirements
- R1: After reset, `in_ready` is 1, and both `txn_valid` and `grp_done` are 0.
- R2: A lane's segment is its address with the low log2(SEG_BYTES) bits dropped. `txn_addr` is that segment with the low log2(SEG_BYTES) bits set to zero.
- R3: Each transaction takes its segment from the lowest-numbered pending lane. Its `txn_mask` (bit i means lane i) holds every pending lane in that segment and no other lane.
- R4: A lane whose `in_active` bit is 0 never appears in any `txn_mask`, whatever its address.
- R5: At the `grp_done` pulse, `grp_txns` equals the number of distinct segments among the group's active lanes.
- R6: A group whose active lanes all lie in one segment is served by exactly one transaction, and that transaction's mask equals `in_active`.
- R7: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid`, `txn_addr` and `txn_mask` hold their values into the next cycle.
- R8: `grp_done` is high for exactly one cycle. That cycle follows the handshake of the group's last transaction. For a group with no active lanes, it follows the accept cycle, and no transaction is issued.
- R9: `in_ready` is 0 from the cycle after an accept through the `grp_done` cycle, and is 1 again in the following cycle. While `in_ready` is 0, `in_valid` is ignored.
- R10: Across one group, the transaction masks are disjoint and their union equals `in_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A group is offered |
| in_ready | output | 1 | The unit can take a group |
| in_active | input | LANES | Active-lane mask, bit i for lane i |
| in_addr | input | LANES*AW | Lane byte addresses, lane i at bits [i*AW +: AW] |
| txn_valid | output | 1 | A transaction is offered |
| txn_ready | input | 1 | The memory side takes the transaction |
| txn_addr | output | AW | Aligned segment base address |
| txn_mask | output | LANES | Lanes served by this transaction |
| grp_done | output | 1 | One-cycle pulse when the group is fully served |
| grp_txns | output | CW | Transaction count of the group just finished |

## Verification
The bench drives a fully coalesced group, which a unit that splits lanes by position would turn into several transactions. It drives one stray lane, which a unit that only compares neighbours might miss or count twice. It drives eight lanes in eight separate segments, and a lane that is inactive but sits in a fresh segment; a unit that ignored the mask would emit a phantom transaction for that lane. A group with no active lanes must finish without issuing anything, where a careless state machine would hang or issue an empty mask. Random backpressure and an `in_valid` held high across groups show whether a transaction changes while stalled or a group is taken before the done pulse.

// File: rtl/mem_coalescer.sv
module mem_coalescer #(
  parameter int LANES     = 8,
  parameter int AW        = 32,
  parameter int SEG_BYTES = 64,
  localparam int CW       = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES-1:0]      in_active,
  input  logic [LANES*AW-1:0]   in_addr,
  output logic                  txn_valid,
  input  logic                  txn_ready,
  output logic [AW-1:0]         txn_addr,
  output logic [LANES-1:0]      txn_mask,
  output logic                  grp_done,
  output logic [CW-1:0]         grp_txns
);
  localparam int OFF = $clog2(SEG_BYTES);
  localparam int LIW = $clog2(LANES);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t                 state_q;
  logic [AW-1:0]          addr_q [LANES];
  logic [LANES-1:0]       pend_q;
  logic [LANES-1:0]       act_q;
  logic [CW-1:0]          cnt_q;
  logic [LIW-1:0]         lead;
  logic [AW-OFF-1:0]      lead_seg;
  logic [LANES-1:0]       hit;
  logic                   accept, fire;

  assign in_ready  = (state_q == S_IDLE);
  assign txn_valid = (state_q == S_RUN);
  assign grp_done  = (state_q == S_FIN);
  assign grp_txns  = cnt_q;
  assign accept    = in_valid && in_ready;
  assign fire      = txn_valid && txn_ready;

  always_comb begin
    lead = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (pend_q[i]) lead = LIW'(i);
  end

  assign lead_seg = addr_q[lead][AW-1:OFF];

  for (genvar g = 0; g < LANES; g++) begin : g_hit
    assign hit[g] = pend_q[g] && (addr_q[g][AW-1:OFF] == lead_seg);
  end

  assign txn_mask = hit;
  assign txn_addr = {lead_seg, {OFF{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pend_q  <= '0;
      act_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          pend_q  <= in_active;
          act_q   <= in_active;
          cnt_q   <= '0;
          state_q <= (in_active == '0) ? S_FIN : S_RUN;
        end
        S_RUN: if (fire) begin
          pend_q <= pend_q & ~hit;
          cnt_q  <= cnt_q + 1'b1;
          if ((pend_q & ~hit) == '0) state_q <= S_FIN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_addr
    always_ff @(posedge clk)
      if (accept) addr_q[g] <= in_addr[g*AW +: AW];
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr) && $stable(txn_mask));

  // R3
  mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> $countones(txn_mask) >= 1);

  // R4
  inactive_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_mask & ~act_q) == '0);

  // R10
  served_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pend_q & $past(txn_mask)) == '0);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> !grp_done);

  // R9
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> in_ready);

  // R9
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !in_ready);

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |-> grp_txns <= CW'(LANES));
endmodule

// File: tb/sim_mem_coalescer.sv
module sim_mem_coalescer;
  localparam int LANES = 8;
  localparam int AW = 32;
  localparam int SEG = 64;
  localparam int OFF = $clog2(SEG);
  localparam int CW = $clog2(LANES + 1);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [LANES-1:0] in_active = '0;
  logic [LANES*AW-1:0] in_addr = '0;
  logic txn_valid, txn_ready = 1, grp_done;
  logic [AW-1:0] txn_addr;
  logic [LANES-1:0] txn_mask;
  logic [CW-1:0] grp_txns;

  always #2.5 clk = ~clk;

  mem_coalescer #(.LANES(LANES), .AW(AW), .SEG_BYTES(SEG)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_active(in_active), .in_addr(in_addr), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_addr(txn_addr), .txn_mask(txn_mask),
    .grp_done(grp_done), .grp_txns(grp_txns));

  int checks = 0, fails = 0;
  logic [AW-1:0] q_addr[$];
  logic [LANES-1:0] q_mask[$];
  bit busy = 0, exp_done = 0, stalled = 0, rand_ready = 0;
  int exp_cnt = 0, accepts = 0, dones = 0, last_cnt = 0;
  logic [LANES-1:0] last_mask = '0, grp_act = '0, union_m = '0;
  logic [AW-1:0] st_addr = '0;
  logic [LANES-1:0] st_mask = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      txn_ready = rand_ready ? (($urandom % 3) != 0) : 1'b1;
      chk(grp_done == exp_done, "R8 done timing", grp_done, exp_done);
      if (exp_done) begin
        chk(int'(grp_txns) == exp_cnt, "R5 txn count", grp_txns, exp_cnt);
        chk(union_m == grp_act, "R10 mask union", union_m, grp_act);
        last_cnt = int'(grp_txns);
      end
      chk(in_ready == !busy, "R9 in_ready", in_ready, !busy);
      chk(txn_valid == (busy && !exp_done && q_addr.size() > 0), "R8 txn_valid",
          txn_valid, busy && !exp_done && q_addr.size() > 0);
      if (stalled)
        chk(txn_valid && txn_addr == st_addr && txn_mask == st_mask, "R7 stall hold",
            txn_addr, st_addr);
      stalled = 0;
      if (exp_done) begin
        exp_done = 0; busy = 0; dones++;
      end else if (txn_valid && q_addr.size() > 0) begin
        if (txn_ready) begin
          chk(txn_addr == q_addr[0], "R2 txn_addr", txn_addr, q_addr[0]);
          chk(txn_mask == q_mask[0], "R3 txn_mask", txn_mask, q_mask[0]);
          chk((txn_mask & ~grp_act) == '0, "R4 inactive lane", txn_mask, grp_act);
          chk((txn_mask & union_m) == '0, "R10 disjoint", txn_mask, union_m);
          union_m |= txn_mask;
          last_mask = txn_mask;
          void'(q_addr.pop_front()); void'(q_mask.pop_front());
          if (q_addr.size() == 0) exp_done = 1;
        end else begin
          stalled = 1; st_addr = txn_addr; st_mask = txn_mask;
        end
      end
      if (in_valid && in_ready && !busy) begin
        logic [LANES-1:0] pend;
        pend = in_active;
        grp_act = in_active; union_m = '0;
        while (pend != '0) begin
          int ld;
          logic [LANES-1:0] m;
          ld = 0;
          for (int i = LANES - 1; i >= 0; i--) if (pend[i]) ld = i;
          m = '0;
          for (int j = 0; j < LANES; j++)
            if (pend[j] && (in_addr[j*AW +: AW] >> OFF) == (in_addr[ld*AW +: AW] >> OFF))
              m[j] = 1'b1;
          q_addr.push_back((in_addr[ld*AW +: AW] >> OFF) << OFF);
          q_mask.push_back(m);
          pend &= ~m;
        end
        exp_cnt = q_addr.size();
        busy = 1; accepts++;
        if (exp_cnt == 0) exp_done = 1;
      end
    end
  end

  task automatic send(input logic [LANES-1:0] act, input logic [LANES*AW-1:0] a, input bit hold);
    int d;
    @(posedge clk); #1;
    in_active = act; in_addr = a; in_valid = 1;
    d = dones;
    while (accepts == 0 || !busy) @(posedge clk);
    #1;
    if (!hold) in_valid = 0;
    in_active = ~act; in_addr = ~a;
    while (dones == d) @(posedge clk);
    #1;
  endtask

  function automatic logic [LANES*AW-1:0] seq(input logic [AW-1:0] base, input int stride);
    logic [LANES*AW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*AW +: AW] = base + AW'(i * stride);
    return r;
  endfunction

  initial begin
    logic [LANES*AW-1:0] a;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(in_ready && !txn_valid && !grp_done, "R1 reset state",
        {in_ready, txn_valid, grp_done}, 3'b100);
    // R6 all lanes in one segment, consecutive words
    send('1, seq(32'h1000, 4), 0);
    chk(last_cnt == 1 && last_mask == '1, "R6 one transaction", last_cnt, 1);
    // R3 one stray lane outside the segment
    a = seq(32'h2000, 4); a[7*AW +: AW] = 32'h5008;
    send('1, a, 0);
    chk(last_cnt == 2, "R3 stray lane two txns", last_cnt, 2);
    // R5 every lane its own segment
    send('1, seq(32'h0, SEG), 0);
    chk(last_cnt == LANES, "R5 distinct segments", last_cnt, LANES);
    // R4 inactive lane in a fresh segment
    a = seq(32'h3000, 4); a[2*AW +: AW] = 32'h9000;
    send(8'b1111_1011, a, 0);
    chk(last_cnt == 1, "R4 inactive ignored", last_cnt, 1);
    // R8 empty group
    send('0, seq(32'h4000, 4), 0);
    chk(last_cnt == 0, "R8 empty group", last_cnt, 0);
    // R7 random groups with backpressure, R9 with in_valid held high
    rand_ready = 1;
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < LANES; i++)
        a[i*AW +: AW] = AW'(($urandom % 4) * SEG * 3 + ($urandom % SEG));
      send(LANES'($urandom), a, (n % 3) == 0);
    end
    in_valid = 0;
    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule